// File: doc/BRIEF.md
# Interrupt Acknowledge Capture Unit

This block stands in for a processor on a bus that is under test. When an interrupt request comes in and automatic acknowledge is allowed, it runs a sequence of two acknowledge bus cycles with an idle gap between them. During the last cycle of the second acknowledge it samples the 8-bit vector type and the 3-bit cascade address that the interrupt controller under test drives. It does not branch to a service routine. Instead it stores both values and raises a "vector available" flag in its status word. It also drives a frame pulse that a scope or logic probe can trigger on to watch the acknowledge timing.

A host reaches the unit through single-cycle strobes that its own address decoder has already decoded. Three of the strobes read data back:
- a consuming read returns the vector type and re-arms capture;
- a non-consuming read returns the vector type and leaves the unit locked;
- a third read returns the cascade address.

A force strobe starts an acknowledge sequence at any time, even while the unit is locked. A configuration write turns automatic acknowledge on or off. Strobes that arrive in the same cycle are queued and served one per clock.

Top module: `irq_ack_capture`

## Requirements
- R1: An acknowledge sequence drives `ack_o` high for ACK_LEN cycles, low for GAP_LEN cycles, then high for ACK_LEN cycles. The defaults are 2, 1 and 2, which gives the `ack_o` pattern 1,1,0,1,1.
- R2: On the last cycle of the second acknowledge, `bus_vec_i` and `bus_cas_i` are stored and the available flag is set. The flag is bit FLAG_BIT of `status_o` (default bit 11, so the status word reads 12'h800), and every other status bit reads 0.
- R3: While the available flag is high, a high `irq_i` starts no acknowledge sequence.
- R4: A consuming read (`rd_rearm_i`) puts the stored vector on `rdata_o` with `rvalid_o` high on the clock after the strobe is served, and clears the flag. If a capture lands on the same edge, the capture wins and the flag stays set.
- R5: A non-consuming read (`rd_peek_i`) returns the stored vector and leaves the flag unchanged.
- R6: A cascade read (`rd_cas_i`) returns the stored cascade address zero-extended into the low bits of `rdata_o`.
- R7: A force strobe (`wr_force_i`) starts a sequence whatever the flag and the enable setting are. If a sequence is already running, the new one starts after it ends.
- R8: Automatic acknowledge needs both a low flag and a set enable. The enable is written through `cfg_we_i`/`cfg_en_i` and comes out of reset as enabled.
- R9: `sync_o` rises together with the first acknowledge cycle and falls when the second acknowledge cycle ends. `ack_o` is only ever high inside that frame.
- R10: `irq_i` passes through a SYNC_STAGES-flop synchronizer (default 2). A request set up before edge k starts the sequence on edge k+2.
- R11: Strobes are served one per clock. Force comes first, then consuming read, then non-consuming read, then cascade read. A strobe that is not served stays pending.
- R12: Reset clears the flag, `rdata_o`, `rvalid_o`, `ack_o` and `sync_o`, and stops any sequence that is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 1 | Asynchronous interrupt request |
| cfg_we_i | input | 1 | Write strobe for the enable setting |
| cfg_en_i | input | 1 | Enable value to write |
| rd_rearm_i | input | 1 | Consuming vector read strobe |
| rd_peek_i | input | 1 | Non-consuming vector read strobe |
| rd_cas_i | input | 1 | Cascade address read strobe |
| wr_force_i | input | 1 | Forced acknowledge strobe |
| bus_vec_i | input | VEC_W | Vector type driven by the controller under test |
| bus_cas_i | input | CAS_W | Cascade address driven by the controller under test |
| ack_o | output | 1 | Acknowledge cycle active |
| sync_o | output | 1 | Frame pulse around the acknowledge pair |
| status_o | output | STAT_W | Status word carrying the available flag |
| rdata_o | output | VEC_W | Host read data |
| rvalid_o | output | 1 | Host read data valid, one cycle |

## Verification
The checker makes three assumptions about the environment:
- every strobe is a one-cycle pulse from a decoded host address;
- the controller under test holds `bus_vec_i` and `bus_cas_i` steady for the whole second acknowledge cycle;
- no strobe changes the enable setting partway through a sequence in a way that the checker's own copy of the last enable write could not follow.

The bench changes inputs only on falling edges. It sets the bus values before each sequence starts and keeps them fixed until the flag rises. It holds `irq_i` high until capture and then drops it, and it waits for the synchronizer to clear before it re-arms. This ensures that any extra acknowledge the bench sees comes from the design and not from a request that was left behind.

// File: rtl/irq_cap_pkg.sv
package irq_cap_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE,
      SEQ_ACK1,
      SEQ_GAP,
      SEQ_ACK2
   } seq_state_e;

   typedef enum logic [1:0] {
      HOST_NONE,
      HOST_REARM,
      HOST_PEEK,
      HOST_CAS
   } host_op_e;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/irq_cap_sync.sv
module irq_cap_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic async_i,
   output logic sync_o
);
   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], async_i};
   end

   assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/irq_cap_seq.sv
module irq_cap_seq
   import irq_cap_pkg::*;
#(
   parameter int unsigned ACK_LEN = 2,
   parameter int unsigned GAP_LEN = 1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   output logic idle_o,
   output logic ack_o,
   output logic frame_o,
   output logic cap_o
);
   localparam int unsigned LONGEST = (ACK_LEN > GAP_LEN) ? ACK_LEN : GAP_LEN;
   localparam int unsigned CW      = cnt_width(LONGEST);

   seq_state_e    state_q;
   logic [CW-1:0] cnt_q;
   logic          last_ack, last_gap;

   assign last_ack = (cnt_q == CW'(ACK_LEN - 1));
   assign last_gap = (cnt_q == CW'(GAP_LEN - 1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= SEQ_IDLE;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            SEQ_IDLE: begin
               cnt_q <= '0;
               if (start_i) state_q <= SEQ_ACK1;
            end
            SEQ_ACK1: begin
               cnt_q <= last_ack ? '0 : cnt_q + 1'b1;
               if (last_ack) state_q <= SEQ_GAP;
            end
            SEQ_GAP: begin
               cnt_q <= last_gap ? '0 : cnt_q + 1'b1;
               if (last_gap) state_q <= SEQ_ACK2;
            end
            default: begin
               cnt_q <= last_ack ? '0 : cnt_q + 1'b1;
               if (last_ack) state_q <= SEQ_IDLE;
            end
         endcase
      end
   end

   assign idle_o  = (state_q == SEQ_IDLE);
   assign ack_o   = (state_q == SEQ_ACK1) || (state_q == SEQ_ACK2);
   assign frame_o = !idle_o;
   assign cap_o   = (state_q == SEQ_ACK2) && last_ack;
endmodule

// File: rtl/irq_cap_host.sv
module irq_cap_host
   import irq_cap_pkg::*;
#(
   parameter int unsigned VEC_W = 8,
   parameter int unsigned CAS_W = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             rd_rearm_i,
   input  logic             rd_peek_i,
   input  logic             rd_cas_i,
   input  logic             wr_force_i,
   input  logic             cfg_we_i,
   input  logic             cfg_en_i,
   input  logic             irq_s_i,
   input  logic             idle_i,
   input  logic             cap_i,
   input  logic [VEC_W-1:0] bus_vec_i,
   input  logic [CAS_W-1:0] bus_cas_i,
   output logic             start_o,
   output logic             flag_o,
   output logic [VEC_W-1:0] rdata_o,
   output logic             rvalid_o
);
   logic             pend_frc_q, pend_rearm_q, pend_peek_q, pend_cas_q;
   logic             frc_any, rearm_any, peek_any, cas_any;
   logic             start_force, start_auto;
   logic             en_q, flag_q;
   logic [VEC_W-1:0] vec_store_q, cas_ext;
   logic [CAS_W-1:0] cas_store_q;
   host_op_e         op;

   assign frc_any   = pend_frc_q   | wr_force_i;
   assign rearm_any = pend_rearm_q | rd_rearm_i;
   assign peek_any  = pend_peek_q  | rd_peek_i;
   assign cas_any   = pend_cas_q   | rd_cas_i;

   assign start_force = idle_i & frc_any;
   assign start_auto  = idle_i & irq_s_i & en_q & ~flag_q;
   assign start_o     = start_force | start_auto;

   always_comb begin
      op = HOST_NONE;
      if (!start_force) begin
         if      (rearm_any) op = HOST_REARM;
         else if (peek_any)  op = HOST_PEEK;
         else if (cas_any)   op = HOST_CAS;
      end
   end

   if (CAS_W < VEC_W) begin : g_cas_pad
      assign cas_ext = {{(VEC_W - CAS_W){1'b0}}, cas_store_q};
   end else begin : g_cas_full
      assign cas_ext = cas_store_q;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_frc_q   <= 1'b0;
         pend_rearm_q <= 1'b0;
         pend_peek_q  <= 1'b0;
         pend_cas_q   <= 1'b0;
         en_q         <= 1'b1;
         flag_q       <= 1'b0;
         vec_store_q  <= '0;
         cas_store_q  <= '0;
         rdata_o      <= '0;
         rvalid_o     <= 1'b0;
      end else begin
         pend_frc_q   <= frc_any & ~start_force;
         pend_rearm_q <= rearm_any & (op != HOST_REARM);
         pend_peek_q  <= peek_any & (op != HOST_PEEK);
         pend_cas_q   <= cas_any & (op != HOST_CAS);
         if (cfg_we_i) en_q <= cfg_en_i;
         if (cap_i) begin
            vec_store_q <= bus_vec_i;
            cas_store_q <= bus_cas_i;
            flag_q      <= 1'b1;
         end else if (op == HOST_REARM) begin
            flag_q <= 1'b0;
         end
         rvalid_o <= (op != HOST_NONE);
         unique case (op)
            HOST_REARM, HOST_PEEK: rdata_o <= vec_store_q;
            HOST_CAS:              rdata_o <= cas_ext;
            default:               rdata_o <= rdata_o;
         endcase
      end
   end

   assign flag_o = flag_q;
endmodule

// File: rtl/irq_ack_capture.sv
module irq_ack_capture #(
   parameter int unsigned VEC_W       = 8,
   parameter int unsigned CAS_W       = 3,
   parameter int unsigned STAT_W      = 12,
   parameter int unsigned FLAG_BIT    = 11,
   parameter int unsigned ACK_LEN     = 2,
   parameter int unsigned GAP_LEN     = 1,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              irq_i,
   input  logic              cfg_we_i,
   input  logic              cfg_en_i,
   input  logic              rd_rearm_i,
   input  logic              rd_peek_i,
   input  logic              rd_cas_i,
   input  logic              wr_force_i,
   input  logic [VEC_W-1:0]  bus_vec_i,
   input  logic [CAS_W-1:0]  bus_cas_i,
   output logic              ack_o,
   output logic              sync_o,
   output logic [STAT_W-1:0] status_o,
   output logic [VEC_W-1:0]  rdata_o,
   output logic              rvalid_o
);
   if (SYNC_STAGES < 2)     begin : g_bad_sync  $error("SYNC_STAGES must be 2 or more"); end
   if (CAS_W > VEC_W)       begin : g_bad_cas   $error("CAS_W must not exceed VEC_W"); end
   if (FLAG_BIT >= STAT_W)  begin : g_bad_flag  $error("FLAG_BIT outside status word"); end
   if (ACK_LEN < 1 || GAP_LEN < 1) begin : g_bad_len $error("cycle lengths must be 1 or more"); end

   logic irq_s, idle, cap, start, flag;

   irq_cap_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .async_i(irq_i), .sync_o(irq_s)
   );

   irq_cap_seq #(.ACK_LEN(ACK_LEN), .GAP_LEN(GAP_LEN)) seq_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .idle_o(idle),
      .ack_o(ack_o), .frame_o(sync_o), .cap_o(cap)
   );

   irq_cap_host #(.VEC_W(VEC_W), .CAS_W(CAS_W)) host_i (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .rd_rearm_i(rd_rearm_i), .rd_peek_i(rd_peek_i), .rd_cas_i(rd_cas_i),
      .wr_force_i(wr_force_i), .cfg_we_i(cfg_we_i), .cfg_en_i(cfg_en_i),
      .irq_s_i(irq_s), .idle_i(idle), .cap_i(cap),
      .bus_vec_i(bus_vec_i), .bus_cas_i(bus_cas_i),
      .start_o(start), .flag_o(flag), .rdata_o(rdata_o), .rvalid_o(rvalid_o)
   );

   for (genvar gi = 0; gi < STAT_W; gi++) begin : g_stat
      if (gi == FLAG_BIT) begin : g_flag
         assign status_o[gi] = flag;
      end else begin : g_zero
         assign status_o[gi] = 1'b0;
      end
   end
endmodule

// File: rtl/irq_ack_capture_chk.sv
module irq_ack_capture_chk #(
   parameter int unsigned ACK_LEN = 2,
   parameter int unsigned GAP_LEN = 1
) (
   input logic clk_i,
   input logic rst_ni,
   input logic wr_force_i,
   input logic rd_rearm_i,
   input logic cfg_we_i,
   input logic cfg_en_i,
   input logic ack_o,
   input logic sync_o,
   input logic flag_i
);
   localparam int unsigned SEQ_LEN = 2 * ACK_LEN + GAP_LEN;

   logic [15:0] frame_cnt_q;
   logic        frc_out_q, rearm_out_q, en_seen_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         frame_cnt_q <= '0;
         frc_out_q   <= 1'b0;
         rearm_out_q <= 1'b0;
         en_seen_q   <= 1'b1;
      end else begin
         frame_cnt_q <= sync_o ? frame_cnt_q + 16'd1 : 16'd0;
         if (wr_force_i)        frc_out_q <= 1'b1;
         else if (sync_o && !$past(sync_o)) frc_out_q <= 1'b0;
         if (rd_rearm_i)        rearm_out_q <= 1'b1;
         else if (!flag_i && $past(flag_i)) rearm_out_q <= 1'b0;
         if (cfg_we_i)          en_seen_q <= cfg_en_i;
      end
   end

   // R1: a frame lasts exactly two acknowledges plus the gap
   assert_frame_len_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(sync_o) |-> frame_cnt_q == 16'(SEQ_LEN));

   // R2: a finished frame leaves the available flag set
   assert_flag_after_frame_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(sync_o) |-> flag_i);

   // R3 / R8: an automatic start needs a low flag and an enabled setting
   assert_lock_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(sync_o) && !frc_out_q) |-> (!$past(flag_i) && $past(en_seen_q)));

   // R4: the flag only drops after a consuming read
   assert_rearm_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(flag_i) |-> rearm_out_q);

   // R9: acknowledge stays inside the frame
   assert_ack_in_frame_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_o |-> sync_o);

   // R9: the frame opens with an acknowledge cycle
   assert_frame_opens_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sync_o) |-> ack_o);
endmodule

bind irq_ack_capture irq_ack_capture_chk #(
   .ACK_LEN(ACK_LEN),
   .GAP_LEN(GAP_LEN)
) chk_i (
   .clk_i(clk_i),
   .rst_ni(rst_ni),
   .wr_force_i(wr_force_i),
   .rd_rearm_i(rd_rearm_i),
   .cfg_we_i(cfg_we_i),
   .cfg_en_i(cfg_en_i),
   .ack_o(ack_o),
   .sync_o(sync_o),
   .flag_i(status_o[FLAG_BIT])
);

// File: tb/irq_ack_capture_tb_top.sv
module irq_ack_capture_tb_top;
   localparam logic [11:0] FLAG_WORD = 12'h800;
   // entries: [11] request path (1 = irq_i, 0 = force), [10:8] cascade, [7:0] vector
   localparam logic [5:0][11:0] TV = {
      12'h1_3C, 12'h6_A5, 12'hF_FF, 12'h0_00, 12'hA_81, 12'h3_08
   };

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n = 1'b0, irq = 1'b0, cfg_we = 1'b0, cfg_en = 1'b0;
   logic rd_rearm = 1'b0, rd_peek = 1'b0, rd_cas = 1'b0, wr_force = 1'b0;
   logic [7:0]  bus_vec = '0;
   logic [2:0]  bus_cas = '0;
   logic        ack, sync;
   logic [11:0] status;
   logic [7:0]  rdata;
   logic        rvalid;
   int          n_cmp = 0, n_bad = 0;
   bit          done = 1'b0;

   irq_ack_capture dut_i (
      .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .cfg_we_i(cfg_we), .cfg_en_i(cfg_en),
      .rd_rearm_i(rd_rearm), .rd_peek_i(rd_peek), .rd_cas_i(rd_cas), .wr_force_i(wr_force),
      .bus_vec_i(bus_vec), .bus_cas_i(bus_cas), .ack_o(ack), .sync_o(sync),
      .status_o(status), .rdata_o(rdata), .rvalid_o(rvalid)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   // which: 0 consuming, 1 non-consuming, 2 cascade
   task automatic host_read(input int which, input logic [7:0] exp, input string req);
      rd_rearm = (which == 0);
      rd_peek  = (which == 1);
      rd_cas   = (which == 2);
      step();
      rd_rearm = 1'b0; rd_peek = 1'b0; rd_cas = 1'b0;
      chk(req, "rvalid", 32'(rvalid), 32'd1);
      chk(req, "rdata", 32'(rdata), 32'(exp));
   endtask

   // walks one sequence whose first acknowledge cycle has just begun
   task automatic walk_frame(input string req);
      for (int k = 0; k < 5; k++) begin
         if (k > 0) step();
         chk("R1", "ack pattern", 32'(ack), 32'((k < 2) || (k >= 3)));
         chk("R9", "sync in frame", 32'(sync), 32'd1);
      end
      chk(req, "flag before capture", 32'(status), 32'd0);
      step();
      chk("R2", "flag after capture", 32'(status), 32'(FLAG_WORD));
      chk("R9", "sync after frame", 32'(sync), 32'd0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int quiet;
      step(); step();
      // R12 reset state
      chk("R12", "status", 32'(status), 32'd0);
      chk("R12", "ack", 32'(ack), 32'd0);
      chk("R12", "sync", 32'(sync), 32'd0);
      chk("R12", "rdata", 32'(rdata), 32'd0);
      rst_n = 1'b1;
      step();

      // table walk: capture, peek, cascade, rearm (R5 R6 R4)
      for (int i = 0; i < 6; i++) begin
         bus_vec = TV[i][7:0];
         bus_cas = TV[i][10:8];
         if (TV[i][11]) begin
            irq = 1'b1;
            step(); step();
            chk("R10", "no start before sync", 32'(sync), 32'd0);
            step();
            walk_frame("R10");
            irq = 1'b0;
         end else begin
            wr_force = 1'b1;
            step();
            wr_force = 1'b0;
            walk_frame("R7");
         end
         host_read(1, TV[i][7:0], "R5");
         chk("R5", "flag kept", 32'(status), 32'(FLAG_WORD));
         host_read(2, {5'd0, TV[i][10:8]}, "R6");
         host_read(0, TV[i][7:0], "R4");
         chk("R4", "flag cleared", 32'(status), 32'd0);
         step(); step();
      end

      // R3: locked unit ignores a request
      wr_force = 1'b1; bus_vec = 8'h11; bus_cas = 3'd1;
      step(); wr_force = 1'b0;
      repeat (5) step();
      irq = 1'b1;
      quiet = 0;
      for (int k = 0; k < 10; k++) begin step(); quiet += int'(sync); end
      chk("R3", "sync cycles while locked", 32'(quiet), 32'd0);

      // R7: force runs while locked, overwriting the stored vector
      bus_vec = 8'h22; bus_cas = 3'd2;
      wr_force = 1'b1;
      step(); wr_force = 1'b0;
      chk("R7", "forced start while locked", 32'(sync), 32'd1);
      repeat (5) step();
      irq = 1'b0;
      host_read(1, 8'h22, "R7");
      step(); step();

      // R11: force and consuming read together; force first, read next clock
      bus_vec = 8'h33;
      wr_force = 1'b1; rd_rearm = 1'b1;
      step();
      wr_force = 1'b0; rd_rearm = 1'b0;
      chk("R11", "force served first", 32'(sync), 32'd1);
      chk("R11", "read waits", 32'(rvalid), 32'd0);
      step();
      chk("R11", "read next clock", 32'(rvalid), 32'd1);
      chk("R11", "read old vector", 32'(rdata), 32'h22);
      chk("R11", "flag cleared mid frame", 32'(status), 32'd0);
      repeat (4) step();
      chk("R11", "new capture sets flag", 32'(status), 32'(FLAG_WORD));
      // R11: peek before cascade
      bus_cas = 3'd5;
      rd_peek = 1'b1; rd_cas = 1'b1;
      step();
      rd_peek = 1'b0; rd_cas = 1'b0;
      chk("R11", "peek first", 32'(rdata), 32'h33);
      step();
      chk("R11", "cascade second", 32'(rdata), 32'd2);
      host_read(0, 8'h33, "R4");

      // R8: disabled setting blocks auto acknowledge, re-enable resumes it
      cfg_we = 1'b1; cfg_en = 1'b0;
      step(); cfg_we = 1'b0;
      irq = 1'b1;
      quiet = 0;
      for (int k = 0; k < 8; k++) begin step(); quiet += int'(sync); end
      chk("R8", "sync cycles while disabled", 32'(quiet), 32'd0);
      bus_vec = 8'h44;
      cfg_we = 1'b1; cfg_en = 1'b1;
      step(); cfg_we = 1'b0;
      step();
      chk("R8", "start after enable", 32'(sync), 32'd1);
      irq = 1'b0;
      repeat (5) step();
      host_read(1, 8'h44, "R8");
      host_read(0, 8'h44, "R4");

      // R12: reset mid sequence, then R8 default enable acknowledges a request
      wr_force = 1'b1;
      step(); wr_force = 1'b0;
      step();
      rst_n = 1'b0;
      #1;
      chk("R12", "sync in reset", 32'(sync), 32'd0);
      chk("R12", "ack in reset", 32'(ack), 32'd0);
      chk("R12", "rvalid in reset", 32'(rvalid), 32'd0);
      step();
      rst_n = 1'b1;
      step();
      irq = 1'b1;
      step(); step(); step();
      chk("R8", "default enable acknowledges", 32'(sync), 32'd1);
      irq = 1'b0;
      repeat (6) step();

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule